// File: doc/BRIEF.md
# UART Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A byte goes first into a one-entry holding register. When the shifter is free, the byte moves into the shifter. The shifter then sends a low start bit, the data bits least significant first, an optional parity bit and a high stop period. After that the line returns to the high idle level.

A 16-bit divisor sets the timing. A counter divides the system clock by the divisor and produces a one-cycle enable at sixteen times the baud rate. Every serial bit lasts exactly sixteen of these enables. A divisor of 12 with a 1.8432 MHz clock gives 9600 baud. A divisor of zero stops the enables, and a frame in progress then waits.

A line-control byte sets the frame format:
- a word length of 5 to 8 bits;
- one stop bit, or a long stop period;
- optional parity: even, odd, or a fixed (stick) level;
- a break control that holds the line low.

Two flags report progress: one for the holding register and one for the whole transmit path.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, `txd_o` is 1, `hold_empty_o` is 1 and `shift_empty_o` is 1.
- R2: A frame starts with one 0 bit, followed by the data bits least significant first. The number of data bits is set by `line_ctl_i[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: The stop period is set by `line_ctl_i[2]`. At 0 it lasts 16 enables (one bit). At 1 it lasts 24 enables (1.5 bits) with 5 data bits, and 32 enables (2 bits) with 6 to 8 data bits. The line is 1 throughout the stop period.
- R4: With `line_ctl_i[3]`=1, a parity bit follows the data. With `line_ctl_i[4]`=1 it makes the number of ones in data plus parity even. With `line_ctl_i[4]`=0 it makes that number odd.
- R5: With `line_ctl_i[3]`=1 and `line_ctl_i[5]`=1, the parity bit is the inverse of `line_ctl_i[4]`, whatever the data.
- R6: While `line_ctl_i[6]`=1, `txd_o` is 0 from the next cycle on. Frame timing continues underneath, so a frame still ends on schedule.
- R7: The enable fires once every D clocks for a divisor D≥1. Each bit lasts 16·D clocks, except that the start bit may be up to D−1 clocks shorter.
- R8: With a divisor of 0, a frame in progress does not advance. It resumes when a nonzero divisor is applied.
- R9: A write pulls `hold_empty_o` low in the next cycle. If the shifter is idle, the byte is loaded at the following edge. At that edge `hold_empty_o` returns to 1, the start bit begins, and `shift_empty_o` stays 0 until the stop period ends.
- R10: A byte written while a frame is being sent waits in the holding register with `hold_empty_o` low. Its start bit follows one clock after the current stop period ends, and `shift_empty_o` does not rise in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor_i | input | DIV_W (16) | Clock divisor for the 16x enable; 0 stops it |
| line_ctl_i | input | 7 | Frame format: [1:0] word length, [2] long stop, [3] parity enable, [4] even select, [5] stick, [6] break |
| wr_i | input | 1 | One-cycle write strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial line output, idle high |
| hold_empty_o | output | 1 | Holding register is empty |
| shift_empty_o | output | 1 | Holding register and shifter are both idle |

## Verification
The flags change one cycle after their cause.
- `hold_empty_o` falls one edge after the write strobe.
- The load, the rise of `hold_empty_o` and the falling start bit come one edge after that.
- A break takes effect one edge after it is applied.

The bench samples on the falling clock edge exactly those many edges after driving its stimulus.

Serial bits are harder to time, because the free-running divider lets the start bit run up to D−1 clocks short. The bench therefore records the edge at which the start bit appears and samples each bit at 16·D·k + 7·D clocks after it. That point lies inside every bit whatever the divider phase. Frame lengths are checked against the window [T−D+1, T], where T is the frame length computed from the format. The window is widened by one clock for the gap between back-to-back frames.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } tx_phase_e;

    // Frame format captured at load time (break is applied live, not stored)
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] wlen;
    } frame_cfg_t;

    function automatic frame_cfg_t unpack_ctl(input logic [5:0] ctl);
        frame_cfg_t c;
        c.wlen      = ctl[1:0];
        c.long_stop = ctl[2];
        c.par_en    = ctl[3];
        c.even      = ctl[4];
        c.stick     = ctl[5];
        return c;
    endfunction

    // Parity over the active data bits only; stick mode gives a fixed level
    function automatic logic calc_parity(input logic [7:0] data, input frame_cfg_t c);
        logic [7:0] mask;
        logic       ones;
        mask = 8'hFF >> (2'd3 - c.wlen);
        ones = ^(data & mask);
        if (c.stick) begin
            return ~c.even;
        end
        return c.even ? ones : ~ones;
    endfunction

endpackage

// File: rtl/serial_baud_gen.sv
module serial_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } bg_state_t;

    bg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (divisor_i == '0) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= divisor_i - ONE) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    AST_ZERO_DIV_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_i == '0) |=> !tick_o); // R8

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && divisor_i > ONE) |=> !tick_o); // R7

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import serial_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [6:0] line_ctl_i,
    input  logic       wr_i,
    input  logic [7:0] wr_data_i,
    output logic       txd_o,
    output logic       hold_empty_o,
    output logic       shift_empty_o
);

    localparam int TCW = $clog2(2 * OVS);
    localparam logic [TCW-1:0] LAST_BIT    = TCW'(OVS - 1);
    localparam logic [TCW-1:0] LAST_STOP15 = TCW'(OVS + OVS / 2 - 1);
    localparam logic [TCW-1:0] LAST_STOP2  = TCW'(2 * OVS - 1);
    localparam logic [TCW-1:0] TONE        = TCW'(1);

    typedef struct packed {
        tx_phase_e  ph;
        logic [TCW-1:0] tcnt;
        logic [2:0] bidx;
        logic [7:0] shreg;
        logic       par;
        frame_cfg_t cfg;
        logic [7:0] hold;
        logic       full;
        logic       txd;
    } fr_state_t;

    fr_state_t      st_d, st_q;
    logic           load;
    logic           bit_end;
    logic [TCW-1:0] last_tick;
    logic [2:0]     last_data;
    frame_cfg_t     new_cfg;

    always_comb begin
        st_d      = st_q;
        load      = (st_q.ph == PH_IDLE) && st_q.full;
        new_cfg   = unpack_ctl(line_ctl_i[5:0]);
        last_data = 3'd4 + {1'b0, st_q.cfg.wlen};

        if (st_q.ph == PH_STOP) begin
            if (!st_q.cfg.long_stop) begin
                last_tick = LAST_BIT;
            end else if (st_q.cfg.wlen == 2'd0) begin
                last_tick = LAST_STOP15;
            end else begin
                last_tick = LAST_STOP2;
            end
        end else begin
            last_tick = LAST_BIT;
        end
        bit_end = tick_i && (st_q.tcnt == last_tick);

        // holding register: a write wins over the load-side clear
        if (wr_i) begin
            st_d.hold = wr_data_i;
            st_d.full = 1'b1;
        end else if (load) begin
            st_d.full = 1'b0;
        end

        case (st_q.ph)
            PH_IDLE: begin
                if (load) begin
                    st_d.ph    = PH_START;
                    st_d.tcnt  = '0;
                    st_d.bidx  = '0;
                    st_d.shreg = st_q.hold;
                    st_d.cfg   = new_cfg;
                    st_d.par   = calc_parity(st_q.hold, new_cfg);
                end
            end
            default: begin
                if (tick_i) begin
                    if (bit_end) begin
                        st_d.tcnt = '0;
                        case (st_q.ph)
                            PH_START: st_d.ph = PH_DATA;
                            PH_DATA: begin
                                st_d.shreg = {1'b0, st_q.shreg[7:1]};
                                if (st_q.bidx == last_data) begin
                                    st_d.ph = st_q.cfg.par_en ? PH_PAR : PH_STOP;
                                end else begin
                                    st_d.bidx = st_q.bidx + 3'd1;
                                end
                            end
                            PH_PAR:  st_d.ph = PH_STOP;
                            default: st_d.ph = PH_IDLE;
                        endcase
                    end else begin
                        st_d.tcnt = st_q.tcnt + TONE;
                    end
                end
            end
        endcase

        // registered line level, taken from the next phase
        case (st_d.ph)
            PH_START: st_d.txd = 1'b0;
            PH_DATA:  st_d.txd = st_d.shreg[0];
            PH_PAR:   st_d.txd = st_d.par;
            default:  st_d.txd = 1'b1;
        endcase
        if (line_ctl_i[6]) begin
            st_d.txd = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ph  <= PH_IDLE;
            st_q.txd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_o         = st_q.txd;
    assign hold_empty_o  = !st_q.full;
    assign shift_empty_o = !st_q.full && (st_q.ph == PH_IDLE);

    AST_BREAK_FORCES_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl_i[6] |=> !txd_o); // R6

    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !hold_empty_o); // R9

    AST_LOAD_REFILLS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && st_q.full && !wr_i) |=> (hold_empty_o && !shift_empty_o)); // R9

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && st_q.full) |=> !txd_o); // R2

    AST_NO_ADVANCE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && st_q.ph != PH_IDLE) |=> $stable(st_q.ph)); // R8

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic [6:0]       line_ctl_i,
    input  logic             wr_i,
    input  logic [7:0]       wr_data_i,
    output logic             txd_o,
    output logic             hold_empty_o,
    output logic             shift_empty_o
);

    logic tick;

    serial_baud_gen #(
        .DIV_W(DIV_W)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .divisor_i(divisor_i),
        .tick_o   (tick)
    );

    serial_tx_framer #(
        .OVS(OVS)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .line_ctl_i   (line_ctl_i),
        .wr_i         (wr_i),
        .wr_data_i    (wr_data_i),
        .txd_o        (txd_o),
        .hold_empty_o (hold_empty_o),
        .shift_empty_o(shift_empty_o)
    );

endmodule

// File: tb/tb_serial_tx_core.sv
module tb_serial_tx_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd4;
    logic [6:0]  line_ctl = 7'h03;
    logic        wr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        txd_o, hold_empty_o, shift_empty_o;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    serial_tx_core dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .divisor_i    (divisor),
        .line_ctl_i   (line_ctl),
        .wr_i         (wr),
        .wr_data_i    (wr_data),
        .txd_o        (txd_o),
        .hold_empty_o (hold_empty_o),
        .shift_empty_o(shift_empty_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d);
        wr = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // samples every bit of a frame whose start bit appeared at edge c0; returns the nominal length
    task automatic check_frame(input int c0, input logic [6:0] lcr, input logic [7:0] d,
                               input int dv, input string rq, output int tlen);
        logic bits [0:10];
        int   n, nb, stopt, target;
        logic [7:0] mask;
        n = 5 + int'(lcr[1:0]);
        mask = 8'hFF >> (3 - int'(lcr[1:0]));
        bits[0] = 1'b0;
        for (int i = 0; i < n; i++) bits[1+i] = d[i];
        nb = 1 + n;
        if (lcr[3]) begin
            if (lcr[5]) bits[nb] = ~lcr[4];
            else bits[nb] = lcr[4] ? ^(d & mask) : ~^(d & mask);
            nb++;
        end
        stopt = !lcr[2] ? 16 : (n == 5 ? 24 : 32);
        tlen = dv * (16 * nb + stopt);
        for (int k = 0; k <= nb; k++) begin
            target = c0 + 16 * dv * k + 7 * dv;
            while (cyc < target) @(negedge clk);
            if (k < nb) chk(txd_o == bits[k], rq, $sformatf("bit %0d", k), int'(txd_o), int'(bits[k]));
            else chk(txd_o == 1'b1, "R3", "stop level", int'(txd_o), 1);
        end
    endtask

    task automatic wait_empty();
        while (!shift_empty_o) @(negedge clk);
    endtask

    task automatic run_frame(input logic [6:0] lcr, input logic [7:0] d, input int dv, input string rq);
        int c0, t, len;
        line_ctl = lcr;
        divisor = 16'(dv);
        @(negedge clk);
        send_byte(d);
        chk(hold_empty_o == 1'b0, "R9", "hold_empty after write", int'(hold_empty_o), 0);
        @(negedge clk);
        chk(hold_empty_o == 1'b1, "R9", "hold_empty after load", int'(hold_empty_o), 1);
        chk(shift_empty_o == 1'b0, "R9", "shift_empty after load", int'(shift_empty_o), 0);
        c0 = cyc;
        check_frame(c0, lcr, d, dv, rq, t);
        wait_empty();
        len = cyc - c0;
        chk(len >= t - dv + 1 && len <= t, "R7", {rq, " frame length"}, len, t);
    endtask

    task automatic t_reset();
        chk(txd_o == 1'b1, "R1", "txd at reset", int'(txd_o), 1);
        chk(hold_empty_o == 1'b1, "R1", "hold_empty at reset", int'(hold_empty_o), 1);
        chk(shift_empty_o == 1'b1, "R1", "shift_empty at reset", int'(shift_empty_o), 1);
    endtask

    task automatic t_break();
        int c0, t, len, lowbad;
        line_ctl = 7'h43;
        @(negedge clk);
        chk(txd_o == 1'b0, "R6", "break while idle", int'(txd_o), 0);
        line_ctl = 7'h03;
        @(negedge clk);
        chk(txd_o == 1'b1, "R6", "release break idle", int'(txd_o), 1);
        divisor = 16'd4;
        send_byte(8'hFF);
        @(negedge clk);
        c0 = cyc;
        t = 4 * 16 * 10;
        repeat (40) @(negedge clk);
        line_ctl = 7'h43;
        @(negedge clk);
        lowbad = 0;
        repeat (100) begin
            if (txd_o != 1'b0) lowbad++;
            @(negedge clk);
        end
        chk(lowbad == 0, "R6", "line low during break", lowbad, 0);
        line_ctl = 7'h03;
        wait_empty();
        len = cyc - c0;
        chk(len >= t - 3 && len <= t, "R6", "frame timing under break", len, t);
    endtask

    task automatic t_zero_div();
        int c0, t, len;
        line_ctl = 7'h03;
        divisor = 16'd0;
        repeat (2) @(negedge clk);
        send_byte(8'h55);
        @(negedge clk);
        chk(txd_o == 1'b0, "R8", "start bit with zero divisor", int'(txd_o), 0);
        repeat (300) @(negedge clk);
        chk(txd_o == 1'b0, "R8", "no advance txd", int'(txd_o), 0);
        chk(shift_empty_o == 1'b0, "R8", "no advance shift_empty", int'(shift_empty_o), 0);
        divisor = 16'd3;
        c0 = cyc;
        t = 3 * 16 * 10;
        wait_empty();
        len = cyc - c0;
        chk(len >= t - 3 && len <= t + 3, "R8", "resume length", len, t);
    endtask

    task automatic t_back_to_back();
        int c0, c1, t, t2, len, gapbad;
        line_ctl = 7'h03;
        divisor = 16'd2;
        @(negedge clk);
        send_byte(8'h81);
        @(negedge clk);
        c0 = cyc;
        send_byte(8'h7E);
        chk(hold_empty_o == 1'b0, "R10", "second byte waits", int'(hold_empty_o), 0);
        check_frame(c0, 7'h03, 8'h81, 2, "R10", t);
        chk(hold_empty_o == 1'b0, "R10", "still waiting at stop", int'(hold_empty_o), 0);
        gapbad = 0;
        while (txd_o != 1'b0) begin
            if (shift_empty_o) gapbad++;
            @(negedge clk);
        end
        c1 = cyc;
        chk(gapbad == 0, "R10", "shift_empty rose between frames", gapbad, 0);
        chk(c1 - c0 >= t - 1 + 2 - 2 && c1 - c0 <= t + 1, "R10", "second start timing", c1 - c0, t + 1);
        chk(hold_empty_o == 1'b1, "R10", "hold_empty at second load", int'(hold_empty_o), 1);
        check_frame(c1, 7'h03, 8'h7E, 2, "R10", t2);
        wait_empty();
        len = cyc - c1;
        chk(len >= t2 - 1 && len <= t2, "R10", "second frame length", len, t2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_frame(7'h03, 8'hA5, 4, "R2");   // 8 data, 1 stop
        run_frame(7'h04, 8'h1B, 4, "R3");   // 5 data, 1.5 stop
        run_frame(7'h1E, 8'h53, 4, "R4");   // 7 data, even parity, 2 stop
        run_frame(7'h09, 8'h2D, 1, "R4");   // 6 data, odd parity
        run_frame(7'h3B, 8'hFF, 4, "R5");   // stick, even select -> parity 0
        run_frame(7'h2B, 8'h00, 4, "R5");   // stick, odd select -> parity 1
        run_frame(7'h07, 8'h3C, 2, "R3");   // 8 data, 2 stop
        run_frame(7'h00, 8'h0A, 5, "R7");   // 5 data, divisor 5
        t_break();
        t_zero_div();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule